// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit is the purely combinational hazard controller of a five-stage in-order pipeline. Each cycle it reads the register numbers and control bits held in the four pipeline registers, along with the branch outcome resolved in the execute stage. From these it chooses where each ALU operand comes from: the register file, the memory-stage result or the writeback-stage result. It also decides whether the front end must hold for a load-use interlock and whether the two youngest instructions must be squashed after a taken branch.

The datapath multiplexers, the pipeline registers and the branch resolution logic sit outside the unit. Only this unit's select and enable outputs drive them. The decode stage supplies one flag per source operand to say whether the instruction really reads it. A load therefore stalls only consumers that use the loaded register.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: `fwd_a_sel` is 2'b10 (memory-stage result) when `exmem_reg_write` is 1, `exmem_rd` is nonzero and `exmem_rd` equals `idex_rs`.
- R2: When R1 does not apply, `fwd_a_sel` is 2'b01 (writeback-stage result) if `memwb_reg_write` is 1, `memwb_rd` is nonzero and `memwb_rd` equals `idex_rs`. A memory-stage match always beats a writeback-stage match.
- R3: When neither R1 nor R2 applies, `fwd_a_sel` is 2'b00 (register file value).
- R4: `fwd_b_sel` follows R1 to R3 with the same encoding, comparing against `idex_rt` in place of `idex_rs`.
- R5: Register 0 is never a forwarding source. An operand whose source register number is 0 always selects 2'b00.
- R6: A load-use stall is raised when `idex_mem_read` is 1, `idex_rt` is nonzero, `ex_branch_taken` is 0, and either (`ifid_uses_rs` is 1 and `ifid_rs` equals `idex_rt`) or (`ifid_uses_rt` is 1 and `ifid_rt` equals `idex_rt`). During the stall, `pc_we` is 0, `ifid_we` is 0 and `idex_bubble` is 1. A load into register 0 never stalls.
- R7: A register match on an operand whose use flag is 0 does not cause a stall.
- R8: When `ex_branch_taken` is 1, `ifid_flush` and `idex_flush` are both 1, `pc_we` and `ifid_we` are both 1, and `idex_bubble` is 0.
- R9: When a taken branch and a load-use condition occur together, the flush of R8 is produced and no stall is raised.
- R10: With neither a stall nor a taken branch, `pc_we` and `ifid_we` are 1 and `idex_bubble`, `ifid_flush` and `idex_flush` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ifid_rs | input | REG_W | First source register of the instruction in decode |
| ifid_rt | input | REG_W | Second source register of the instruction in decode |
| ifid_uses_rs | input | 1 | Decode instruction actually reads `ifid_rs` |
| ifid_uses_rt | input | 1 | Decode instruction actually reads `ifid_rt` |
| idex_rs | input | REG_W | First source register of the instruction in execute |
| idex_rt | input | REG_W | Second source register, and load destination, in execute |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| exmem_reg_write | input | 1 | Memory-stage instruction writes a register |
| exmem_rd | input | REG_W | Memory-stage destination register |
| memwb_reg_write | input | 1 | Writeback-stage instruction writes a register |
| memwb_rd | input | REG_W | Writeback-stage destination register |
| ex_branch_taken | input | 1 | Branch resolved taken in execute |
| fwd_a_sel | output | 2 | Operand A source select |
| fwd_b_sel | output | 2 | Operand B source select |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| idex_bubble | output | 1 | Zero the control bits entering ID/EX |
| ifid_flush | output | 1 | Squash the instruction in IF/ID |
| idex_flush | output | 1 | Squash the instruction in ID/EX |

## Verification
The bench builds the unit with REG_W = 2, which gives four registers including register 0. At that width, two sweeps each cover 1024 input combinations exhaustively. The first sweep enumerates every combination of the execute-stage sources and both producers' destinations and write enables. It therefore reaches every priority case between the memory and writeback stages and every register-0 case. The second sweep enumerates the decode sources, both use flags, the load destination, the load flag and the branch outcome. It reaches every stall, flush and overlap case of R6 to R10.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    localparam int MAX_REG_W = 8;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } opnd_src_e;

    typedef struct packed {
        logic we;
        logic [MAX_REG_W-1:0] rd;
    } producer_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic idex_bubble;
        logic ifid_flush;
        logic idex_flush;
    } pipe_ctrl_t;

    localparam pipe_ctrl_t CTRL_RUN   = '{pc_we: 1'b1, ifid_we: 1'b1, idex_bubble: 1'b0,
                                          ifid_flush: 1'b0, idex_flush: 1'b0};
    localparam pipe_ctrl_t CTRL_STALL = '{pc_we: 1'b0, ifid_we: 1'b0, idex_bubble: 1'b1,
                                          ifid_flush: 1'b0, idex_flush: 1'b0};
    localparam pipe_ctrl_t CTRL_FLUSH = '{pc_we: 1'b1, ifid_we: 1'b1, idex_bubble: 1'b0,
                                          ifid_flush: 1'b1, idex_flush: 1'b1};

    // A producer can feed a consumer register only if it writes a nonzero register equal to it.
    function automatic logic producer_hits(producer_t p, logic [MAX_REG_W-1:0] src);
        return p.we && (p.rd != '0) && (p.rd == src);
    endfunction

endpackage

// File: rtl/operand_fwd_sel.sv
module operand_fwd_sel
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_reg,
    input  producer_t        mem_prod,
    input  producer_t        wb_prod,
    output opnd_src_e        sel
);
    logic [MAX_REG_W-1:0] src_ext;
    logic                 mem_hit;
    logic                 wb_hit;

    always_comb begin
        src_ext = '0;
        src_ext[REG_W-1:0] = src_reg;
    end

    assign mem_hit = producer_hits(mem_prod, src_ext);
    assign wb_hit  = producer_hits(wb_prod, src_ext);

    // Younger producer (memory stage) carries the newest value and wins.
    always_comb begin
        if (mem_hit)     sel = SRC_MEM;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_REGFILE;
    end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] dec_rs,
    input  logic [REG_W-1:0] dec_rt,
    input  logic             dec_uses_rs,
    input  logic             dec_uses_rt,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] ex_load_dst,
    output logic             hazard
);
    logic rs_dep;
    logic rt_dep;
    logic dst_live;

    assign dst_live = ex_is_load && (ex_load_dst != '0);
    assign rs_dep   = dec_uses_rs && (dec_rs == ex_load_dst);
    assign rt_dep   = dec_uses_rt && (dec_rt == ex_load_dst);
    assign hazard   = dst_live && (rs_dep || rt_dep);
endmodule

// File: rtl/pipe_ctrl_arbiter.sv
module pipe_ctrl_arbiter
    import hazard_pkg::*;
(
    input  logic       load_use,
    input  logic       branch_taken,
    output pipe_ctrl_t ctrl
);
    // Squash outranks the interlock: the stalled consumer is itself on the wrong path.
    always_comb begin
        if (branch_taken)  ctrl = CTRL_FLUSH;
        else if (load_use) ctrl = CTRL_STALL;
        else               ctrl = CTRL_RUN;
    end
endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] ifid_rs,
    input  logic [REG_W-1:0] ifid_rt,
    input  logic             ifid_uses_rs,
    input  logic             ifid_uses_rt,
    input  logic [REG_W-1:0] idex_rs,
    input  logic [REG_W-1:0] idex_rt,
    input  logic             idex_mem_read,
    input  logic             exmem_reg_write,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             memwb_reg_write,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             ex_branch_taken,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             pc_we,
    output logic             ifid_we,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic             idex_flush
);
    localparam int N_OPND = 2;

    producer_t        mem_prod;
    producer_t        wb_prod;
    logic [REG_W-1:0] opnd_reg [N_OPND];
    opnd_src_e        opnd_sel [N_OPND];
    logic             load_use;
    pipe_ctrl_t       ctrl;

    always_comb begin
        mem_prod    = '0;
        mem_prod.we = exmem_reg_write;
        mem_prod.rd[REG_W-1:0] = exmem_rd;
        wb_prod     = '0;
        wb_prod.we  = memwb_reg_write;
        wb_prod.rd[REG_W-1:0]  = memwb_rd;
    end

    assign opnd_reg[0] = idex_rs;
    assign opnd_reg[1] = idex_rt;

    for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
        operand_fwd_sel #(.REG_W(REG_W)) u_sel (
            .src_reg  (opnd_reg[g]),
            .mem_prod (mem_prod),
            .wb_prod  (wb_prod),
            .sel      (opnd_sel[g])
        );
    end

    load_use_detect #(.REG_W(REG_W)) u_lud (
        .dec_rs      (ifid_rs),
        .dec_rt      (ifid_rt),
        .dec_uses_rs (ifid_uses_rs),
        .dec_uses_rt (ifid_uses_rt),
        .ex_is_load  (idex_mem_read),
        .ex_load_dst (idex_rt),
        .hazard      (load_use)
    );

    pipe_ctrl_arbiter u_arb (
        .load_use     (load_use),
        .branch_taken (ex_branch_taken),
        .ctrl         (ctrl)
    );

    assign fwd_a_sel   = opnd_sel[0];
    assign fwd_b_sel   = opnd_sel[1];
    assign pc_we       = ctrl.pc_we;
    assign ifid_we     = ctrl.ifid_we;
    assign idex_bubble = ctrl.idex_bubble;
    assign ifid_flush  = ctrl.ifid_flush;
    assign idex_flush  = ctrl.idex_flush;
endmodule

// File: rtl/hazard_ctrl_unit_chk.sv
module hazard_ctrl_unit_chk #(
    parameter int REG_W = 5
) (
    input logic [REG_W-1:0] idex_rs,
    input logic [REG_W-1:0] idex_rt,
    input logic             exmem_reg_write,
    input logic [REG_W-1:0] exmem_rd,
    input logic             ex_branch_taken,
    input logic [1:0]       fwd_a_sel,
    input logic [1:0]       fwd_b_sel,
    input logic             pc_we,
    input logic             ifid_we,
    input logic             idex_bubble,
    input logic             ifid_flush,
    input logic             idex_flush
);
    logic known;
    assign known = !$isunknown({idex_rs, idex_rt, exmem_reg_write, exmem_rd, ex_branch_taken,
                                fwd_a_sel, fwd_b_sel, pc_we, ifid_we, idex_bubble,
                                ifid_flush, idex_flush});

    always_comb begin
        if (known) begin
            // R2
            fwd_a_mem_prio_chk: assert (!(exmem_reg_write && exmem_rd != '0 && exmem_rd == idex_rs)
                                        || fwd_a_sel == 2'b10)
                else $error("operand A ignored memory-stage match");
            // R5
            fwd_a_zero_chk: assert (idex_rs != '0 || fwd_a_sel == 2'b00)
                else $error("register 0 forwarded on operand A");
            // R5
            fwd_b_zero_chk: assert (idex_rt != '0 || fwd_b_sel == 2'b00)
                else $error("register 0 forwarded on operand B");
            // R4
            fwd_b_legal_chk: assert (fwd_b_sel != 2'b11)
                else $error("illegal operand B select");
            // R8
            branch_flush_chk: assert (!ex_branch_taken || (ifid_flush && idex_flush && pc_we))
                else $error("taken branch without flush");
            // R9
            stall_flush_excl_chk: assert (!(idex_bubble && (ifid_flush || idex_flush)))
                else $error("stall and flush together");
            // R10
            front_hold_chk: assert (pc_we == ifid_we && pc_we == !idex_bubble)
                else $error("front-end enables disagree");
        end
    end
endmodule

bind hazard_ctrl_unit hazard_ctrl_unit_chk #(.REG_W(REG_W)) u_chk (
    .idex_rs         (idex_rs),
    .idex_rt         (idex_rt),
    .exmem_reg_write (exmem_reg_write),
    .exmem_rd        (exmem_rd),
    .ex_branch_taken (ex_branch_taken),
    .fwd_a_sel       (fwd_a_sel),
    .fwd_b_sel       (fwd_b_sel),
    .pc_we           (pc_we),
    .ifid_we         (ifid_we),
    .idex_bubble     (idex_bubble),
    .ifid_flush      (ifid_flush),
    .idex_flush      (idex_flush)
);

// File: tb/hazard_ctrl_unit_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_unit_tb_top;
    localparam int W = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] ifid_rs = '0, ifid_rt = '0, idex_rs = '0, idex_rt = '0;
    logic [W-1:0] exmem_rd = '0, memwb_rd = '0;
    logic ifid_uses_rs = 1'b0, ifid_uses_rt = 1'b0, idex_mem_read = 1'b0;
    logic exmem_reg_write = 1'b0, memwb_reg_write = 1'b0, ex_branch_taken = 1'b0;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    hazard_ctrl_unit #(.REG_W(W)) dut_i (
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt), .ifid_uses_rs(ifid_uses_rs),
        .ifid_uses_rt(ifid_uses_rt), .idex_rs(idex_rs), .idex_rt(idex_rt),
        .idex_mem_read(idex_mem_read), .exmem_reg_write(exmem_reg_write),
        .exmem_rd(exmem_rd), .memwb_reg_write(memwb_reg_write), .memwb_rd(memwb_rd),
        .ex_branch_taken(ex_branch_taken), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [W-1:0] src);
        if (exmem_reg_write && exmem_rd != 0 && exmem_rd == src) return 2'b10;
        if (memwb_reg_write && memwb_rd != 0 && memwb_rd == src) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [1:0] s);
        if (s == 2'b10) return "R1";
        if (s == 2'b01) return "R2";
        return "R3";
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: idle state with all fields zero
        chk("R10", {pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush}, 5'b11000);
        chk("R3", fwd_a_sel, 0);

        // Forwarding sweep: idex_rs, idex_rt, both producers
        for (int v = 0; v < 1024; v++) begin
            @(posedge clk);
            {idex_rs, idex_rt, exmem_reg_write, exmem_rd, memwb_reg_write, memwb_rd} = v[9:0];
            @(negedge clk);
            chk(sel_tag(exp_sel(idex_rs)), fwd_a_sel, exp_sel(idex_rs));
            chk("R4", fwd_b_sel, exp_sel(idex_rt));
            if (idex_rs == 0) chk("R5", fwd_a_sel, 0);
            if (idex_rt == 0) chk("R5", fwd_b_sel, 0);
        end

        exmem_reg_write = 1'b0; memwb_reg_write = 1'b0;
        // Hazard sweep: decode sources, use flags, load dst, load flag, branch
        for (int v = 0; v < 1024; v++) begin
            logic raw_lu, lu, unqual;
            logic [4:0] exp;
            string tag;
            @(posedge clk);
            {ifid_rs, ifid_rt, ifid_uses_rs, ifid_uses_rt, idex_rt, idex_mem_read,
             ex_branch_taken} = v[9:0];
            unqual = idex_mem_read && (ifid_rs == idex_rt || ifid_rt == idex_rt);
            raw_lu = idex_mem_read && idex_rt != 0 &&
                     ((ifid_uses_rs && ifid_rs == idex_rt) || (ifid_uses_rt && ifid_rt == idex_rt));
            lu = raw_lu && !ex_branch_taken;
            if (ex_branch_taken)  exp = 5'b11011;
            else if (lu)          exp = 5'b00100;
            else                  exp = 5'b11000;
            if (ex_branch_taken && raw_lu)   tag = "R9";
            else if (ex_branch_taken)        tag = "R8";
            else if (lu)                     tag = "R6";
            else if (unqual && idex_rt == 0) tag = "R6";
            else if (unqual)                 tag = "R7";
            else                             tag = "R10";
            @(negedge clk);
            chk(tag, {pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush}, exp);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule